// File: doc/BRIEF.md
# Parity Stripe Controller with Erase Hiding

This block sits between a host request port and the five storage modules of one protection group. A write request carries four data chunks. The block computes their XOR parity and stores the five chunks on the five modules in the same cycle. The parity slot rotates with the stripe index, so parity load is spread over all modules. Each stored word carries a CRC-8 over its chunk.

A read fetches the whole stripe from every module that is free. At most one module of the group is allowed into garbage collection or erase at a time, and the block grants that right itself. A module that holds the grant is never sent a read. Its chunk is rebuilt at once from the other four, so a read never waits behind a multi-millisecond erase. A chunk whose CRC fails is also rebuilt, and the response flags the stripe for repair. If two chunks are missing or bad, the read is reported as uncorrectable and no data is returned.

Chunk width, tag width and stripe index width are parameters. The default chunk of 16 bits stands in for a 1 KB chunk.

Top module: `stripe_guard`

## Requirements
- R1: For stripe `s`, let `p = s % 5`. Data chunk `k` (request bits `[k*CHUNK_W +: CHUNK_W]`, k = 0..3) is written to module `(p+1+k) % 5`. All five write enables are high together in the single cycle after the request is accepted.
- R2: Module `p` receives the bytewise XOR of the request's four data chunks only. A write issues no read enable to any module.
- R3: Every word sent to a module is `{crc, chunk}`, where `crc` is the top 8 bits. The CRC uses polynomial x^8+x^2+x+1 with initial value 0 and is fed with the chunk MSB first.
- R4: A read with all modules free and all CRCs correct returns the four stored chunks in request order. It echoes the tag and reports rebuilt, uncorrectable and repair all as 0.
- R5: At most one grant bit is ever high. While one module holds the grant, requests from other modules are not granted.
- R6: A read gives no read enable to the module holding the grant and completes while that grant is still held. If that module holds a data chunk, the chunk is rebuilt from the other four and rebuilt=1. If it holds parity, rebuilt=0. In both cases the data is correct.
- R7: A returned chunk whose CRC does not match sets repair=1 and is replaced by parity reconstruction. A bad data chunk gives rebuilt=1. A bad parity chunk gives rebuilt=0. In both cases the data is correct.
- R8: If two chunks of a stripe are unavailable (busy or CRC-bad), the read reports uncorrectable=1 and rebuilt=0, and the data is all zero.
- R9: The grant is cleared in the cycle after its holder pulses done. The next grant goes round-robin to the first requester after the last holder, in increasing module index modulo 5.
- R10: After reset, reqReady=1 and rspValid=0, and no write enable, read enable or grant is asserted.
- R11: A write is answered in the cycle after acceptance with rspValid=1, rspWrite=1 and the request tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Block can accept a request |
| reqWrite | input | 1 | 1 = write stripe, 0 = read stripe |
| reqTag | input | TAG_W | Request tag, echoed in the response |
| reqStripe | input | IDX_W | Stripe index |
| reqData | input | 4*CHUNK_W | Four data chunks for a write |
| rspValid | output | 1 | Response valid, one-cycle pulse |
| rspWrite | output | 1 | Response belongs to a write |
| rspTag | output | TAG_W | Tag of the answered request |
| rspData | output | 4*CHUNK_W | Read data, four chunks |
| rspRebuilt | output | 1 | A data chunk was reconstructed from parity |
| rspUncorr | output | 1 | Two chunks unavailable, data invalid |
| rspRepair | output | 1 | A CRC mismatch was seen on this stripe |
| modWrEn | output | 5 | Per-module write enable |
| modRdEn | output | 5 | Per-module read enable |
| modAddr | output | IDX_W | Stripe index for all modules |
| modWrData | output | 5*(CHUNK_W+8) | Per-module write word {crc, chunk} |
| modRdValid | input | 5 | Per-module read data valid |
| modRdData | input | 5*(CHUNK_W+8) | Per-module read word {crc, chunk} |
| gcReq | input | 5 | Module asks for garbage-collection permission |
| gcDone | input | 5 | Module finished its erase |
| gcGrant | output | 5 | Garbage-collection permission, one-hot or zero |

## Verification
The assertions assume the following about the modules:
- A module answers each read enable with exactly one valid pulse and has at most one read outstanding.
- A module pulses done only while it holds the grant.
- A module drops its request once it is granted.

The bench module models keep to these rules. Each has its own read latency, and its erase lasts a fixed number of cycles. Host requests are sent one at a time and only when reqReady is high. Each model counts any read that arrives during its erase, so a read sent to a busy module is seen at the ports.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int NUM_MOD  = 5;
  localparam int NUM_DATA = 4;
  localparam int CRC_W    = 8;

  typedef struct packed {
    logic launchWr;
    logic launchRd;
    logic finish;
  } sgStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_FIN} sgState_t;
endpackage

// File: rtl/sg_gc_arbiter.sv
module sg_gc_arbiter #(
  parameter int NM = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NM-1:0] gcReq,
  input  logic [NM-1:0] gcDone,
  input  logic          allowNew,
  output logic [NM-1:0] gcGrant
);
  localparam int IW = $clog2(NM);

  logic [IW-1:0] lastIdx;
  logic          found;
  int            pickIdx;

  always_comb begin
    found   = 1'b0;
    pickIdx = 0;
    for (int i = 1; i <= NM; i++) begin
      int idx;
      idx = (int'(lastIdx) + i) % NM;
      if (!found && gcReq[idx]) begin
        found   = 1'b1;
        pickIdx = idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gcGrant <= '0;
      lastIdx <= IW'(NM - 1);
    end else if ((gcGrant & gcDone) != '0) begin
      gcGrant <= '0;
    end else if (gcGrant == '0 && allowNew && found) begin
      gcGrant          <= '0;
      gcGrant[pickIdx] <= 1'b1;
      lastIdx          <= IW'(pickIdx);
    end
  end
endmodule

// File: rtl/sg_ctrl.sv
module sg_ctrl
  import sg_pkg::*;
#(
  parameter int NM = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [NM-1:0] gcGrant,
  input  logic [NM-1:0] modRdValid,
  output logic          reqReady,
  output logic          allowGc,
  output sgStrobe_t     strobe
);
  sgState_t      state;
  logic [NM-1:0] pend;
  logic [NM-1:0] pendNext;
  logic          accept;

  always_comb begin
    reqReady        = (state == ST_IDLE);
    accept          = reqValid && reqReady;
    strobe.launchWr = accept && reqWrite;
    strobe.launchRd = accept && !reqWrite;
    strobe.finish   = (state == ST_FIN);
    allowGc         = (state == ST_IDLE) && !reqValid;
    pendNext        = pend & ~modRdValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pend  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (strobe.launchRd) begin
          pend  <= ~gcGrant;
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          pend <= pendNext;
          if (pendNext == '0) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sg_datapath.sv
module sg_datapath
  import sg_pkg::*;
#(
  parameter int CHUNK_W = 16,
  parameter int TAG_W   = 4,
  parameter int IDX_W   = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  sgStrobe_t                     strobe,
  input  logic [TAG_W-1:0]              reqTag,
  input  logic [IDX_W-1:0]              reqStripe,
  input  logic [NUM_DATA*CHUNK_W-1:0]   reqData,
  input  logic [NUM_MOD-1:0]            gcGrant,
  input  logic [NUM_MOD-1:0]            modRdValid,
  input  logic [NUM_MOD*(CHUNK_W+CRC_W)-1:0] modRdData,
  output logic [NUM_MOD-1:0]            modWrEn,
  output logic [NUM_MOD-1:0]            modRdEn,
  output logic [IDX_W-1:0]              modAddr,
  output logic [NUM_MOD*(CHUNK_W+CRC_W)-1:0] modWrData,
  output logic                          rspValid,
  output logic                          rspWrite,
  output logic [TAG_W-1:0]              rspTag,
  output logic [NUM_DATA*CHUNK_W-1:0]   rspData,
  output logic                          rspRebuilt,
  output logic                          rspUncorr,
  output logic                          rspRepair
);
  localparam int CW = CHUNK_W + CRC_W;
  localparam int PW = $clog2(NUM_MOD);

  function automatic logic [CRC_W-1:0] crcOf(input logic [CHUNK_W-1:0] d);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = CHUNK_W - 1; i >= 0; i--) begin
      if (c[CRC_W-1] ^ d[i]) c = {c[CRC_W-2:0], 1'b0} ^ CRC_W'(8'h07);
      else                   c = {c[CRC_W-2:0], 1'b0};
    end
    return c;
  endfunction

  logic [TAG_W-1:0]   curTag;
  logic [PW-1:0]      parPos;
  logic [NUM_MOD-1:0] missMask;
  logic [NUM_MOD-1:0] crcOk;
  logic [CHUNK_W-1:0] capData [NUM_MOD];

  // write side: parity and rotated placement
  int                 newPar;
  logic [CHUNK_W-1:0] parityNew;
  logic [CHUNK_W-1:0] wrChunk [NUM_MOD];

  always_comb begin
    newPar    = int'(reqStripe % NUM_MOD);
    parityNew = '0;
    for (int k = 0; k < NUM_DATA; k++) parityNew ^= reqData[k*CHUNK_W +: CHUNK_W];
    for (int m = 0; m < NUM_MOD; m++) begin
      int slot;
      slot = (m + NUM_MOD - 1 - newPar) % NUM_MOD;
      if (slot == NUM_DATA) wrChunk[m] = parityNew;
      else                  wrChunk[m] = reqData[slot*CHUNK_W +: CHUNK_W];
    end
  end

  // read side: reconstruction
  logic [NUM_MOD-1:0]          bad;
  logic [CHUNK_W-1:0]          goodXor;
  logic [NUM_DATA*CHUNK_W-1:0] outData;
  int                          nBad;

  always_comb begin
    bad     = missMask | ~crcOk;
    nBad    = $countones(bad);
    goodXor = '0;
    for (int m = 0; m < NUM_MOD; m++)
      if (!bad[m]) goodXor ^= capData[m];
    for (int k = 0; k < NUM_DATA; k++) begin
      int mm;
      mm = (int'(parPos) + 1 + k) % NUM_MOD;
      outData[k*CHUNK_W +: CHUNK_W] = bad[mm] ? goodXor : capData[mm];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modWrEn    <= '0;
      modRdEn    <= '0;
      modAddr    <= '0;
      modWrData  <= '0;
      rspValid   <= 1'b0;
      rspWrite   <= 1'b0;
      rspTag     <= '0;
      rspData    <= '0;
      rspRebuilt <= 1'b0;
      rspUncorr  <= 1'b0;
      rspRepair  <= 1'b0;
      curTag     <= '0;
      parPos     <= '0;
      missMask   <= '0;
      crcOk      <= '1;
      for (int m = 0; m < NUM_MOD; m++) capData[m] <= '0;
    end else begin
      modWrEn  <= strobe.launchWr ? '1 : '0;
      modRdEn  <= strobe.launchRd ? ~gcGrant : '0;
      rspValid <= strobe.launchWr || strobe.finish;
      if (strobe.launchWr || strobe.launchRd) modAddr <= reqStripe;
      if (strobe.launchWr) begin
        for (int m = 0; m < NUM_MOD; m++)
          modWrData[m*CW +: CW] <= {crcOf(wrChunk[m]), wrChunk[m]};
        rspWrite   <= 1'b1;
        rspTag     <= reqTag;
        rspData    <= '0;
        rspRebuilt <= 1'b0;
        rspUncorr  <= 1'b0;
        rspRepair  <= 1'b0;
      end
      if (strobe.launchRd) begin
        curTag   <= reqTag;
        parPos   <= PW'(newPar);
        missMask <= gcGrant;
        crcOk    <= '1;
      end
      for (int m = 0; m < NUM_MOD; m++) begin
        if (modRdValid[m]) begin
          capData[m] <= modRdData[m*CW +: CHUNK_W];
          crcOk[m]   <= (crcOf(modRdData[m*CW +: CHUNK_W]) == modRdData[m*CW+CHUNK_W +: CRC_W]);
        end
      end
      if (strobe.finish) begin
        rspWrite   <= 1'b0;
        rspTag     <= curTag;
        rspData    <= (nBad > 1) ? '0 : outData;
        rspRebuilt <= (nBad == 1) && !bad[parPos];
        rspUncorr  <= (nBad > 1);
        rspRepair  <= (crcOk != '1);
      end
    end
  end
endmodule

// File: rtl/stripe_guard.sv
module stripe_guard
  import sg_pkg::*;
#(
  parameter int CHUNK_W = 16,
  parameter int TAG_W   = 4,
  parameter int IDX_W   = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               reqValid,
  output logic                               reqReady,
  input  logic                               reqWrite,
  input  logic [TAG_W-1:0]                   reqTag,
  input  logic [IDX_W-1:0]                   reqStripe,
  input  logic [NUM_DATA*CHUNK_W-1:0]        reqData,
  output logic                               rspValid,
  output logic                               rspWrite,
  output logic [TAG_W-1:0]                   rspTag,
  output logic [NUM_DATA*CHUNK_W-1:0]        rspData,
  output logic                               rspRebuilt,
  output logic                               rspUncorr,
  output logic                               rspRepair,
  output logic [NUM_MOD-1:0]                 modWrEn,
  output logic [NUM_MOD-1:0]                 modRdEn,
  output logic [IDX_W-1:0]                   modAddr,
  output logic [NUM_MOD*(CHUNK_W+CRC_W)-1:0] modWrData,
  input  logic [NUM_MOD-1:0]                 modRdValid,
  input  logic [NUM_MOD*(CHUNK_W+CRC_W)-1:0] modRdData,
  input  logic [NUM_MOD-1:0]                 gcReq,
  input  logic [NUM_MOD-1:0]                 gcDone,
  output logic [NUM_MOD-1:0]                 gcGrant
);
  sgStrobe_t strobe;
  logic      allowGc;

  sg_gc_arbiter #(.NM(NUM_MOD)) uArb (
    .clk(clk), .rstN(rstN), .gcReq(gcReq), .gcDone(gcDone),
    .allowNew(allowGc), .gcGrant(gcGrant)
  );

  sg_ctrl #(.NM(NUM_MOD)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .gcGrant(gcGrant), .modRdValid(modRdValid), .reqReady(reqReady),
    .allowGc(allowGc), .strobe(strobe)
  );

  sg_datapath #(.CHUNK_W(CHUNK_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqTag(reqTag),
    .reqStripe(reqStripe), .reqData(reqData), .gcGrant(gcGrant),
    .modRdValid(modRdValid), .modRdData(modRdData), .modWrEn(modWrEn),
    .modRdEn(modRdEn), .modAddr(modAddr), .modWrData(modWrData),
    .rspValid(rspValid), .rspWrite(rspWrite), .rspTag(rspTag),
    .rspData(rspData), .rspRebuilt(rspRebuilt), .rspUncorr(rspUncorr),
    .rspRepair(rspRepair)
  );
endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
  parameter int NM = 5
) (
  input logic          clk,
  input logic          rstN,
  input logic [NM-1:0] gcGrant,
  input logic [NM-1:0] gcDone,
  input logic [NM-1:0] modRdEn,
  input logic [NM-1:0] modWrEn,
  input logic          rspValid,
  input logic          rspRebuilt,
  input logic          rspUncorr
);
  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gcGrant));

  // R5
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gcGrant != '0 && (gcGrant & gcDone) == '0) |=> gcGrant == $past(gcGrant));

  // R9
  grant_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((gcGrant & gcDone) != '0) |=> gcGrant == '0);

  // R6
  no_busy_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modRdEn & gcGrant) == '0);

  // R1
  full_stripe_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    modWrEn != '0 |-> modWrEn == '1);

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !(rspRebuilt && rspUncorr));
endmodule

bind stripe_guard sg_checker #(.NM(5)) uChk (
  .clk(clk), .rstN(rstN), .gcGrant(gcGrant), .gcDone(gcDone),
  .modRdEn(modRdEn), .modWrEn(modWrEn), .rspValid(rspValid),
  .rspRebuilt(rspRebuilt), .rspUncorr(rspUncorr)
);

// File: tb/tb_stripe_guard.sv
module tb_sg_module #(
  parameter int CW        = 24,
  parameter int IDX_W     = 8,
  parameter int ERASE_CYC = 300,
  parameter int READ_LAT  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [IDX_W-1:0] addr,
  input  logic [CW-1:0]    wrData,
  output logic             rdValid,
  output logic [CW-1:0]    rdData,
  input  logic             gcGrant,
  output logic             gcReq,
  output logic             gcDone,
  input  logic             gcKick,
  input  logic             corruptKick,
  input  logic [IDX_W-1:0] peekAddr,
  output logic [CW-1:0]    peekData,
  output int               violations
);
  logic [CW-1:0]    mem [1<<IDX_W];
  logic             erasing, prevGrant, corruptPend;
  int               cnt, rdCnt;
  logic [IDX_W-1:0] rdAddr;

  assign peekData = mem[peekAddr];

  always @(posedge clk) begin
    if (!rstN) begin
      gcReq <= 0; gcDone <= 0; erasing <= 0; prevGrant <= 0; cnt <= 0;
      rdCnt <= 0; rdValid <= 0; rdData <= '0; rdAddr <= '0;
      corruptPend <= 0; violations <= 0;
    end else begin
      prevGrant <= gcGrant;
      gcDone    <= 0;
      rdValid   <= 0;
      if (gcKick) gcReq <= 1;
      if (gcGrant && !prevGrant) begin
        gcReq <= 0; erasing <= 1; cnt <= ERASE_CYC;
      end else if (erasing) begin
        if (cnt == 1) begin erasing <= 0; gcDone <= 1; end
        cnt <= cnt - 1;
      end
      if (corruptKick) corruptPend <= 1;
      if (wrEn) mem[addr] <= wrData;
      if (rdEn) begin
        if (erasing || (gcGrant && !prevGrant)) violations <= violations + 1;
        rdCnt <= READ_LAT; rdAddr <= addr;
      end else if (rdCnt > 0) begin
        rdCnt <= rdCnt - 1;
        if (rdCnt == 1) begin
          rdValid     <= 1;
          rdData      <= mem[rdAddr] ^ {{(CW-1){1'b0}}, corruptPend};
          corruptPend <= 0;
        end
      end
    end
  end
endmodule

module tb_stripe_guard;
  localparam int CHUNK_W = 16;
  localparam int TAG_W   = 4;
  localparam int IDX_W   = 8;
  localparam int CW      = CHUNK_W + 8;
  localparam int DW      = 4 * CHUNK_W;
  localparam int ERASE   = 300;
  localparam int NOPS    = 16;

  logic clk = 0;
  logic rstN = 0;
  always #2.5 clk = ~clk;

  logic             reqValid = 0, reqWrite = 0;
  logic [TAG_W-1:0] reqTag = '0;
  logic [IDX_W-1:0] reqStripe = '0;
  logic [DW-1:0]    reqData = '0;
  logic             reqReady, rspValid, rspWrite, rspRebuilt, rspUncorr, rspRepair;
  logic [TAG_W-1:0] rspTag;
  logic [DW-1:0]    rspData;
  logic [4:0]       modWrEn, modRdEn, modRdValid, gcReq, gcDone, gcGrant;
  logic [IDX_W-1:0] modAddr;
  logic [5*CW-1:0]  modWrData, modRdData;
  logic [4:0]       gcKick = '0, corruptKick = '0;
  logic [IDX_W-1:0] peekAddr = '0;
  logic [CW-1:0]    peekData [5];
  int               viol [5];

  stripe_guard #(.CHUNK_W(CHUNK_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqTag(reqTag), .reqStripe(reqStripe),
    .reqData(reqData), .rspValid(rspValid), .rspWrite(rspWrite),
    .rspTag(rspTag), .rspData(rspData), .rspRebuilt(rspRebuilt),
    .rspUncorr(rspUncorr), .rspRepair(rspRepair), .modWrEn(modWrEn),
    .modRdEn(modRdEn), .modAddr(modAddr), .modWrData(modWrData),
    .modRdValid(modRdValid), .modRdData(modRdData), .gcReq(gcReq),
    .gcDone(gcDone), .gcGrant(gcGrant)
  );

  for (genvar g = 0; g < 5; g++) begin : gMod
    tb_sg_module #(.CW(CW), .IDX_W(IDX_W), .ERASE_CYC(ERASE), .READ_LAT(g + 1)) u (
      .clk(clk), .rstN(rstN), .wrEn(modWrEn[g]), .rdEn(modRdEn[g]),
      .addr(modAddr), .wrData(modWrData[g*CW +: CW]), .rdValid(modRdValid[g]),
      .rdData(modRdData[g*CW +: CW]), .gcGrant(gcGrant[g]), .gcReq(gcReq[g]),
      .gcDone(gcDone[g]), .gcKick(gcKick[g]), .corruptKick(corruptKick[g]),
      .peekAddr(peekAddr), .peekData(peekData[g]), .violations(viol[g])
    );
  end

  int  tests = 0, fails = 0;
  bit  finished = 0;
  logic [DW-1:0] shadow [1<<IDX_W];

  // op bit, stripe, four chunks
  localparam logic [1+IDX_W+DW-1:0] OPS [NOPS] = '{
    {1'b1, 8'd0, 64'h1111_2222_3333_4444},
    {1'b1, 8'd1, 64'hA5A5_5A5A_0F0F_F0F0},
    {1'b1, 8'd2, 64'hDEAD_BEEF_CAFE_0001},
    {1'b1, 8'd3, 64'h0123_4567_89AB_CDEF},
    {1'b1, 8'd4, 64'hFFFF_0000_FFFF_0000},
    {1'b1, 8'd5, 64'h8001_4002_2004_1008},
    {1'b1, 8'd6, 64'h0000_0000_0000_0001},
    {1'b1, 8'd7, 64'h7777_8888_9999_AAAA},
    {1'b1, 8'd8, 64'h1357_9BDF_2468_ACE0},
    {1'b1, 8'd9, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 8'd0, 64'h0},
    {1'b0, 8'd1, 64'h0},
    {1'b0, 8'd4, 64'h0},
    {1'b0, 8'd5, 64'h0},
    {1'b0, 8'd7, 64'h0},
    {1'b0, 8'd9, 64'h0}
  };

  function automatic logic [7:0] crc8(input logic [CHUNK_W-1:0] d);
    logic [7:0] c = 8'h00;
    for (int i = CHUNK_W - 1; i >= 0; i--) begin
      logic fb;
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic sendReq(input logic wr, input logic [IDX_W-1:0] s, input logic [TAG_W-1:0] t, input logic [DW-1:0] d);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqStripe = s; reqTag = t; reqData = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic waitRsp(output bit got);
    got = 0;
    for (int i = 0; i < 50 && !got; i++) begin
      if (rspValid) got = 1;
      else @(negedge clk);
    end
  endtask

  task automatic readCheck(input string req, input logic [IDX_W-1:0] s, input logic [TAG_W-1:0] t,
                           input logic [DW-1:0] expData, input logic eReb, input logic eUnc, input logic eRep);
    bit got;
    sendReq(0, s, t, '0);
    waitRsp(got);
    chk(req, "read response seen", 64'(got), 64'd1);
    chk(req, "read data", rspData, expData);
    chk(req, "tag", 64'(rspTag), 64'(t));
    chk(req, "rebuilt", 64'(rspRebuilt), 64'(eReb));
    chk(req, "uncorrectable", 64'(rspUncorr), 64'(eUnc));
    chk(req, "repair", 64'(rspRepair), 64'(eRep));
  endtask

  task automatic kick(input int m, input bit crc);
    @(negedge clk);
    if (crc) corruptKick[m] = 1; else gcKick[m] = 1;
    @(negedge clk);
    corruptKick = '0; gcKick = '0;
  endtask

  task automatic waitGrant(input string req, input logic [4:0] exp, input int maxc);
    int n = 0;
    while (gcGrant !== exp && n < maxc) begin @(negedge clk); n++; end
    chk(req, "grant", 64'(gcGrant), 64'(exp));
  endtask

  task automatic checkPlacement(input logic [IDX_W-1:0] s, input logic [DW-1:0] d);
    int p = int'(s) % 5;
    logic [CHUNK_W-1:0] par = d[15:0] ^ d[31:16] ^ d[47:32] ^ d[63:48];
    peekAddr = s;
    #1;
    for (int m = 0; m < 5; m++) begin
      int k = (m + 4 - p) % 5;
      logic [CHUNK_W-1:0] e;
      e = (k == 4) ? par : d[k*CHUNK_W +: CHUNK_W];
      if (k == 4) chk("R2", "parity chunk", 64'(peekData[m][CHUNK_W-1:0]), 64'(e));
      else        chk("R1", "data chunk placement", 64'(peekData[m][CHUNK_W-1:0]), 64'(e));
      chk("R3", "stored crc", 64'(peekData[m][CW-1:CHUNK_W]), 64'(crc8(e)));
    end
  endtask

  initial begin
    int vsum;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10", "reqReady", 64'(reqReady), 64'd1);
    chk("R10", "rspValid", 64'(rspValid), 64'd0);
    chk("R10", "enables", 64'({modWrEn, modRdEn}), 64'd0);
    chk("R10", "grant", 64'(gcGrant), 64'd0);
    rstN = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NOPS; i++) begin
      logic              op = OPS[i][1+IDX_W+DW-1];
      logic [IDX_W-1:0]  s  = OPS[i][DW +: IDX_W];
      logic [DW-1:0]     d  = OPS[i][DW-1:0];
      logic [TAG_W-1:0]  t  = TAG_W'(i);
      if (op) begin
        shadow[s] = d;
        sendReq(1, s, t, d);
        chk("R11", "write rspValid", 64'(rspValid), 64'd1);
        chk("R11", "write rspWrite", 64'(rspWrite), 64'd1);
        chk("R11", "write tag", 64'(rspTag), 64'(t));
        chk("R1", "all write enables", 64'(modWrEn), 64'h1f);
        chk("R2", "no reads on write", 64'(modRdEn), 64'd0);
        @(negedge clk);
        checkPlacement(s, d);
      end else begin
        readCheck("R4", s, t, shadow[s], 0, 0, 0);
      end
    end

    // GC grant and erase hiding
    kick(2, 0);
    waitGrant("R5", 5'b00100, 20);
    kick(3, 0);
    repeat (5) @(negedge clk);
    chk("R5", "second request refused", 64'(gcGrant), 64'h04);
    readCheck("R6", 0, 4'hA, shadow[0], 1, 0, 0);
    chk("R6", "grant still held at response", 64'(gcGrant), 64'h04);
    readCheck("R6", 2, 4'hB, shadow[2], 0, 0, 0);
    kick(4, 1);
    readCheck("R8", 0, 4'hC, 64'h0, 0, 1, 1);
    kick(0, 0);
    kick(4, 0);
    waitGrant("R9", 5'b01000, ERASE + 50);
    waitGrant("R9", 5'b10000, ERASE + 50);
    waitGrant("R9", 5'b00001, ERASE + 50);
    waitGrant("R9", 5'b00000, ERASE + 50);

    // CRC mismatch without GC
    kick(1, 1);
    readCheck("R7", 0, 4'hD, shadow[0], 1, 0, 1);
    kick(3, 1);
    readCheck("R7", 3, 4'hE, shadow[3], 0, 0, 1);
    readCheck("R4", 3, 4'hF, shadow[3], 0, 0, 0);

    vsum = 0;
    for (int m = 0; m < 5; m++) vsum += viol[m];
    chk("R6", "reads sent to erasing module", 64'(vsum), 64'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule